// File: doc/BRIEF.md
# Forward 4x4 Walsh-Hadamard Transform

This block takes a 4x4 tile of signed 16-bit samples, usually the sixteen DC terms gathered from the sub-blocks of a macroblock, and returns their forward Walsh-Hadamard transform as sixteen signed 16-bit coefficients. The tile arrives one row of four samples at a time over a valid/ready handshake. Each accepted row goes straight through a horizontal butterfly stage and is stored in a row buffer. Once the fourth row has been stored, a vertical butterfly stage with sign-aware rounding produces the whole tile. The tile is presented in raster order and held until the consumer takes it.

The horizontal stage forms saturated 16-bit pair sums and differences and scales them by four. It adds one to the DC-path term whenever that term's even-pair sum is nonzero. The vertical stage combines the four stored rows of each column, rounds each result towards the odd-biased value, and truncates it to 16 bits. The datapath uses only adders, comparators and fixed shifts.

Top module: `wht4x4_fwd`

## Requirements
- R1: After reset, and after a reset applied part-way through loading a tile, `in_ready_o` is 1 and `out_valid_o` is 0. Rows loaded before that reset have no effect on the next tile.
- R2: While a tile is being collected, `in_ready_o` stays 1. A row is taken only on a cycle where `in_valid_i` and `in_ready_o` are both 1, so idle cycles between rows do not advance the row count. The first accepted row is tile row 0 and the fourth is row 3. Sample k of a row sits at `in_row_i[16k +: 16]`.
- R3: `out_valid_o` is 1 in the cycle that follows the clock edge accepting the fourth row. `in_ready_o` is 0 whenever `out_valid_o` is 1.
- R4: While `out_ready_i` is 0, `out_valid_o` and `out_data_o` hold. On the edge where `out_valid_o` and `out_ready_i` are both 1, the tile is released, and in the next cycle `out_valid_o` is 0 and `in_ready_o` is 1.
- R5: For a row (x0, x1, x2, x3), the row stage computes A=4*S(x0+x2), D=4*S(x1+x3), B=4*S(x0-x2) and C=4*S(x1-x3). It then gives row terms t0=A+D+n, t1=B+C, t2=B-C and t3=A-D.
- R6: The bonus n is 1 when A is nonzero and 0 otherwise. It applies to t0 only.
- R7: For column c with row terms p0..p3, the column stage forms E=p0+p2, F=p1+p3, G=p0-p2 and H=p1-p3. E+F, G+H, G-H and E-F become output rows 0, 1, 2 and 3. Output (row r, column c) sits at `out_data_o[16*(4r+c) +: 16]`.
- R8: Each column result v is rounded as (v + (v<0 ? 1 : 0) + 3) shifted right arithmetically by 3. For example, v=5 gives 1, v=4 gives 0, v=-4 gives 0 and v=-12 gives -1.
- R9: S() saturates to the signed 16-bit range, so 30000+30000 becomes 32767 and (-32768)+(-32768) becomes -32768. Saturation happens before the scaling by 4.
- R10: Rows offered with `in_valid_i` while a tile is pending are neither accepted nor stored. The pending tile is unchanged, and the next tile is computed only from rows accepted after the release.
- R11: The intermediates are wide enough not to overflow. The rounded result is truncated to its low 16 bits, so a tile of all 32767 gives -4 at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A row is offered on in_row_i |
| in_ready_o | output | 1 | The block is collecting rows |
| in_row_i | input | 64 | Four signed 16-bit samples, sample k at bits 16k |
| out_valid_o | output | 1 | A transformed tile is presented |
| out_ready_i | input | 1 | The consumer takes the tile |
| out_data_o | output | 256 | Sixteen signed 16-bit coefficients, raster order |

## Verification
Each row is stored on the edge that accepts it. The transformed tile is therefore due in the cycle right after the edge that accepts the fourth row: the column stage is combinational from the row buffer, and no extra register sits on the way. The bench drives inputs on the falling edge and checks on the next falling edge after that fourth accept. There it checks `out_valid_o`, `in_ready_o` and all sixteen coefficients against a reference model written from the requirements. The release is checked one falling edge after the handshake edge. The hold and ignore behaviour are checked over several stalled cycles before the release.

// File: rtl/wht_pkg.sv
package wht_pkg;
  localparam int unsigned WHT_N = 4;

  typedef enum logic {
    ST_FILL,
    ST_SHOW
  } wht_state_e;
endpackage

// File: rtl/wht_row_pass.sv
module wht_row_pass #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROW_W  = DATA_W + 4
) (
  input  logic [4*DATA_W-1:0] row_i,
  output logic [4*ROW_W-1:0]  row_o
);
  function automatic logic signed [DATA_W-1:0] sat(input logic [DATA_W:0] v);
    if (v[DATA_W] != v[DATA_W-1])
      return v[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    return v[DATA_W-1:0];
  endfunction

  function automatic logic signed [ROW_W-1:0] ext(input logic signed [DATA_W-1:0] v);
    return {{(ROW_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  logic signed [DATA_W-1:0] x0, x1, x2, x3;
  logic signed [DATA_W-1:0] s_ev, s_od, d_ev, d_od;
  logic signed [ROW_W-1:0]  a1, b1, c1, d1;
  logic                     a_nz;

  assign x0 = row_i[0*DATA_W +: DATA_W];
  assign x1 = row_i[1*DATA_W +: DATA_W];
  assign x2 = row_i[2*DATA_W +: DATA_W];
  assign x3 = row_i[3*DATA_W +: DATA_W];

  // saturating pair stage
  assign s_ev = sat({x0[DATA_W-1], x0} + {x2[DATA_W-1], x2});
  assign s_od = sat({x1[DATA_W-1], x1} + {x3[DATA_W-1], x3});
  assign d_ev = sat({x0[DATA_W-1], x0} - {x2[DATA_W-1], x2});
  assign d_od = sat({x1[DATA_W-1], x1} - {x3[DATA_W-1], x3});

  assign a1 = ext(s_ev) <<< 2;
  assign d1 = ext(s_od) <<< 2;
  assign b1 = ext(d_ev) <<< 2;
  assign c1 = ext(d_od) <<< 2;

  assign a_nz = (s_ev != '0);

  assign row_o[0*ROW_W +: ROW_W] = a1 + d1 + {{(ROW_W-1){1'b0}}, a_nz};
  assign row_o[1*ROW_W +: ROW_W] = b1 + c1;
  assign row_o[2*ROW_W +: ROW_W] = b1 - c1;
  assign row_o[3*ROW_W +: ROW_W] = a1 - d1;
endmodule

// File: rtl/wht_col_pass.sv
module wht_col_pass #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROW_W  = DATA_W + 4
) (
  input  logic [4*ROW_W-1:0]  col_i,
  output logic [4*DATA_W-1:0] col_o
);
  localparam int unsigned COL_W = ROW_W + 2;

  function automatic logic signed [COL_W-1:0] ext(input logic signed [ROW_W-1:0] v);
    return {{(COL_W-ROW_W){v[ROW_W-1]}}, v};
  endfunction

  function automatic logic signed [DATA_W-1:0] rnd(input logic signed [COL_W-1:0] v);
    logic signed [COL_W-1:0] t;
    t = v + COL_W'(3) + {{(COL_W-1){1'b0}}, v[COL_W-1]};
    t = t >>> 3;
    return t[DATA_W-1:0];
  endfunction

  logic signed [COL_W-1:0] p0, p1, p2, p3;
  logic signed [COL_W-1:0] e, f, g, h;

  assign p0 = ext(col_i[0*ROW_W +: ROW_W]);
  assign p1 = ext(col_i[1*ROW_W +: ROW_W]);
  assign p2 = ext(col_i[2*ROW_W +: ROW_W]);
  assign p3 = ext(col_i[3*ROW_W +: ROW_W]);

  assign e = p0 + p2;
  assign f = p1 + p3;
  assign g = p0 - p2;
  assign h = p1 - p3;

  assign col_o[0*DATA_W +: DATA_W] = rnd(e + f);
  assign col_o[1*DATA_W +: DATA_W] = rnd(g + h);
  assign col_o[2*DATA_W +: DATA_W] = rnd(g - h);
  assign col_o[3*DATA_W +: DATA_W] = rnd(e - f);
endmodule

// File: rtl/wht_ctrl.sv
module wht_ctrl
  import wht_pkg::*;
#(
  parameter int unsigned ROWS  = WHT_N,
  parameter int unsigned IDX_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  wht_state_e       state_q;
  logic [IDX_W-1:0] cnt_q;
  logic             last_row;

  assign in_ready_o  = (state_q == ST_FILL);
  assign out_valid_o = (state_q == ST_SHOW);
  assign wr_en_o     = in_valid_i && in_ready_o;
  assign wr_idx_o    = cnt_q;
  assign last_row    = (cnt_q == IDX_W'(ROWS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_FILL: if (wr_en_o) begin
          cnt_q <= last_row ? '0 : cnt_q + 1'b1;
          if (last_row) state_q <= ST_SHOW;
        end
        ST_SHOW: if (out_ready_i) state_q <= ST_FILL;
        default: state_q <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/wht4x4_fwd.sv
module wht4x4_fwd
  import wht_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [WHT_N*DATA_W-1:0]       in_row_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [WHT_N*WHT_N*DATA_W-1:0] out_data_o
);
  localparam int unsigned ROW_W = DATA_W + 4;
  localparam int unsigned IDX_W = $clog2(WHT_N);

  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [WHT_N*ROW_W-1:0]   row_res;
  logic [WHT_N*ROW_W-1:0]   rowbuf_q [WHT_N];

  wht_ctrl #(.ROWS(WHT_N), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx)
  );

  wht_row_pass #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_row (
    .row_i (in_row_i),
    .row_o (row_res)
  );

  for (genvar r = 0; r < WHT_N; r++) begin : g_buf
    always_ff @(posedge clk_i) begin
      if (wr_en && wr_idx == IDX_W'(r)) rowbuf_q[r] <= row_res;
    end
  end

  for (genvar c = 0; c < WHT_N; c++) begin : g_col
    logic [WHT_N*ROW_W-1:0]  col_in;
    logic [WHT_N*DATA_W-1:0] col_out;

    for (genvar r = 0; r < WHT_N; r++) begin : g_gather
      assign col_in[r*ROW_W +: ROW_W] = rowbuf_q[r][c*ROW_W +: ROW_W];
      assign out_data_o[(r*WHT_N+c)*DATA_W +: DATA_W] = col_out[r*DATA_W +: DATA_W];
    end

    wht_col_pass #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_col (
      .col_i (col_in),
      .col_o (col_out)
    );
  end
endmodule

// File: rtl/wht4x4_fwd_chk.sv
module wht4x4_fwd_chk #(
  parameter int unsigned IN_W  = 64,
  parameter int unsigned OUT_W = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [IN_W-1:0]  in_row_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o
);
  logic [1:0] seen_q;
  logic       acc;

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (acc) seen_q <= seen_q + 2'd1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o)); // R3

  AST_LAST_ROW_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && seen_q == 2'd3) |=> out_valid_o); // R3

  AST_KEEP_FILLING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && seen_q != 2'd3) |=> (in_ready_o && !out_valid_o)); // R2

  AST_HOLD_TILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R4

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (in_ready_o && !out_valid_o)); // R4

  AST_IGNORE_ROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && in_valid_i && !out_ready_i) |=> $stable(out_data_o)); // R10

  AST_FILL_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> $past(in_valid_i)); // R2
endmodule

bind wht4x4_fwd wht4x4_fwd_chk #(
  .IN_W  (wht_pkg::WHT_N*DATA_W),
  .OUT_W (wht_pkg::WHT_N*wht_pkg::WHT_N*DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_row_i    (in_row_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/wht4x4_fwd_tb_top.sv
module wht4x4_fwd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // stimulus tiles (raster) and hand-derived coefficient at row 0, column 0
  localparam int VEC_IN [NVEC][16] = '{
    '{0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0},
    '{1,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0},
    '{-1,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0},
    '{32767,32767,32767,32767, 32767,32767,32767,32767,
      32767,32767,32767,32767, 32767,32767,32767,32767},
    '{-32768,-32768,-32768,-32768, -32768,-32768,-32768,-32768,
      -32768,-32768,-32768,-32768, -32768,-32768,-32768,-32768},
    '{0,100,200,300, 400,500,600,700, 800,900,1000,1100, 1200,1300,1400,1500},
    '{1000,-1000,1000,-1000, 1000,-1000,1000,-1000,
      1000,-1000,1000,-1000, 1000,-1000,1000,-1000},
    '{30000,-30000,30000,-30000, 30000,-30000,30000,-30000,
      30000,-30000,30000,-30000, 30000,-30000,30000,-30000}
  };
  localparam int VEC_EXP0 [NVEC] = '{0, 1, 0, -4, 1, 6000, 0, -1};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [63:0]  in_row;
  logic         out_valid;
  logic         out_ready;
  logic [255:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wht4x4_fwd dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_row_i    (in_row),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd16(input int v);
    int t;
    logic signed [15:0] s;
    t = (v + ((v < 0) ? 1 : 0) + 3) >>> 3;
    s = t[15:0];
    return int'(s);
  endfunction

  task automatic model(input int x[16], output int y[16]);
    int rt[4][4];
    for (int r = 0; r < 4; r++) begin
      int a, b, c, d;
      a = 4 * sat16(x[4*r] + x[4*r+2]);
      d = 4 * sat16(x[4*r+1] + x[4*r+3]);
      b = 4 * sat16(x[4*r] - x[4*r+2]);
      c = 4 * sat16(x[4*r+1] - x[4*r+3]);
      rt[r][0] = a + d + ((a != 0) ? 1 : 0);
      rt[r][1] = b + c;
      rt[r][2] = b - c;
      rt[r][3] = a - d;
    end
    for (int c = 0; c < 4; c++) begin
      int e, f, g, h;
      e = rt[0][c] + rt[2][c];
      f = rt[1][c] + rt[3][c];
      g = rt[0][c] - rt[2][c];
      h = rt[1][c] - rt[3][c];
      y[0*4+c] = rnd16(e + f);
      y[1*4+c] = rnd16(g + h);
      y[2*4+c] = rnd16(g - h);
      y[3*4+c] = rnd16(e - f);
    end
  endtask

  function automatic int coef(input int k);
    logic signed [15:0] s;
    s = out_data[k*16 +: 16];
    return int'(s);
  endfunction

  task automatic send_rows(input int x[16], input int gap, input int nrows);
    for (int r = 0; r < nrows; r++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", "in_ready while filling", int'(in_ready), 1);
      in_valid = 1'b1;
      for (int k = 0; k < 4; k++) in_row[k*16 +: 16] = x[4*r+k][15:0];
      @(posedge clk);
      if (gap > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_row   = '1;
        repeat (gap) @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_tile(input int x[16], input string req);
    int y[16];
    int bad;
    int bad_k;
    model(x, y);
    bad = 0;
    bad_k = 0;
    for (int k = 0; k < 16; k++)
      if (coef(k) != y[k] && bad == 0) begin
        bad = 1;
        bad_k = k;
      end
    chk(bad == 0, req, $sformatf("coefficient %0d", bad_k), coef(bad_k), y[bad_k]);
  endtask

  task automatic release_tile();
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R4", "out_valid after release", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R4", "in_ready after release", int'(in_ready), 1);
  endtask

  function automatic string tag_of(input int i);
    case (i)
      1: return "R6";
      2: return "R8";
      3: return "R11";
      4: return "R9";
      7: return "R9";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int x[16];
    int y[16];
    int snap;
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      for (int k = 0; k < 16; k++) x[k] = VEC_IN[i][k];
      send_rows(x, i % 3, 4);
      chk(out_valid == 1'b1, "R3", "out_valid after fourth row", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R3", "in_ready while tile pending", int'(in_ready), 0);
      check_tile(x, "R5 R7");
      chk(coef(0) == VEC_EXP0[i], tag_of(i), $sformatf("vector %0d coef 0", i),
          coef(0), VEC_EXP0[i]);
      snap = coef(0);
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b1 && coef(0) == snap, "R4", "hold under stall", coef(0), snap);
      release_tile();
    end

    // R6: bonus only on t0; odd sample at column 1 gives no bonus on its term
    for (int k = 0; k < 16; k++) x[k] = 0;
    x[1] = 1;
    send_rows(x, 0, 4);
    check_tile(x, "R6");
    release_tile();

    // R10: rows offered while a tile is pending are dropped
    for (int k = 0; k < 16; k++) x[k] = VEC_IN[5][k];
    send_rows(x, 0, 4);
    model(x, y);
    @(negedge clk);
    in_valid = 1'b1;
    in_row = {16'h7FFF, 16'h1234, 16'h8000, 16'h4321};
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R10", "in_ready during offered rows", int'(in_ready), 0);
    check_tile(x, "R10");
    release_tile();
    for (int k = 0; k < 16; k++) x[k] = VEC_IN[1][k];
    send_rows(x, 0, 4);
    chk(out_valid == 1'b1, "R10", "count unaffected by dropped rows", int'(out_valid), 1);
    check_tile(x, "R10");
    release_tile();

    // R1: reset part-way through a tile
    for (int k = 0; k < 16; k++) x[k] = 5000 - 700 * k;
    send_rows(x, 0, 2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "ready after mid-tile reset",
        int'(in_ready), 1);
    for (int k = 0; k < 16; k++) x[k] = VEC_IN[7][k];
    send_rows(x, 1, 3);
    chk(out_valid == 1'b0, "R1", "three rows after reset not a tile", int'(out_valid), 0);
    send_rows(x, 0, 1);
    chk(out_valid == 1'b1, "R2", "fourth accepted row completes tile", int'(out_valid), 1);
    for (int k = 0; k < 4; k++) begin
      x[12+k] = VEC_IN[7][k];
      x[8+k]  = VEC_IN[7][k];
      x[4+k]  = VEC_IN[7][k];
    end
    check_tile(x, "R2");
    release_tile();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule